// File: doc/BRIEF.md
# Multi-Lane Video Pixel Deserializer

This block rebuilds one parallel video word per pixel period from one, two or three serial lanes. Every pixel travels as a 30-bit frame: 24 colour bits, three sync bits, some filler bits and one parity bit. A 2-bit lane-count select decides at run time how the frame is spread over the lanes. One lane carries 30 bits per frame, two lanes carry 15 bits each, and three lanes carry 10 bits each. The block runs entirely on an ideal bit clock at the serial rate.

A frame-alignment pulse, coincident with the first bit of a frame, arms the block and resets its bit counter. After the last bit of each frame the block issues a one-cycle valid strobe. The strobe comes with the registered red, green and blue bytes, the three sync flags and a parity-mismatch flag. Filler bits and the parity bit never reach the output. Lanes that the current mode does not use are ignored. A change of the select, or the reserved select code, drops any partial frame. The block then stays silent until the next alignment pulse.

Top module: `pixdeser_top`

## Requirements
- R1: While reset is asserted, and until the first frame completes after reset, every colour, sync, valid and parity-error output is 0.
- R2: With select 00 (one lane), lane 0 carries, first bit first: red bit 7 down to 0, green 7..0, blue 7..0, VS, HS, DE, two filler bits, then parity. One valid strobe follows each 30 bit clocks.
- R3: With select 01 (two lanes), each frame is 15 bits per lane. Lane 0 carries red 7..0, green 7..4, VS, one filler bit, then parity. Lane 1 carries green 3..0, blue 7..0, HS, DE, then one filler bit. One valid strobe follows each 15 bit clocks.
- R4: With select 10 (three lanes), each frame is 10 bits per lane. Lane 0 carries red 7..0, VS, then parity. Lane 1 carries green 7..0, HS, then a filler bit. Lane 2 carries blue 7..0, DE, then a filler bit. One valid strobe follows each 10 bit clocks.
- R5: Filler bit values have no effect on any output.
- R6: Lanes 1 and 2 are ignored with select 00, and lane 2 is ignored with select 01.
- R7: Parity is even by default: the parity bit equals the XOR of the 27 payload bits. On a mismatch, parity_error is 1 in the same cycle as the valid strobe and 0 otherwise.
- R8: Valid is high for exactly one cycle per frame. The output word stays unchanged between strobes.
- R9: When the select changes, any partial frame is discarded and no strobe appears until an alignment pulse arrives with the select held steady.
- R10: With select 11, no strobe is produced and the outputs keep their last values.
- R11: An alignment pulse in the middle of a frame restarts the frame at that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_sel | input | 2 | Lane-count select: 00 one, 01 two, 10 three, 11 reserved |
| frame_start | input | 1 | Alignment pulse, high with the first bit of a frame |
| lane_in | input | 3 | Serial data, bit i is lane i |
| pix_red | output | 8 | Red byte |
| pix_grn | output | 8 | Green byte |
| pix_blu | output | 8 | Blue byte |
| vsync | output | 1 | Vertical sync flag |
| hsync | output | 1 | Horizontal sync flag |
| den | output | 1 | Data-enable flag |
| pix_valid | output | 1 | One-cycle strobe per completed frame |
| parity_error | output | 1 | Parity mismatch on the frame just strobed |

## Verification
Several properties are checked on every cycle:
- the strobe is a single-cycle pulse, spaced at least ten cycles from the previous one;
- the output word stays unchanged between strobes;
- the parity flag appears only together with a strobe;
- the cycle after a select change, and any cycle after the reserved select code, carries no strobe.

The bit-to-field mapping of each mode can only be shown by the bench's frames, which compare the received words with a scoreboard. The same holds for the indifference to filler bits and idle lanes, for the exact strobe period of each mode, and for realignment by a mid-frame pulse.

// File: rtl/pixdeser_pkg.sv
package pixdeser_pkg;

    localparam int COLOR_W    = 8;
    localparam int FRAME_BITS = 30;
    localparam int NUM_LANES  = 3;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        LINK_1    = 2'b00,
        LINK_2    = 2'b01,
        LINK_3    = 2'b10,
        LINK_RSVD = 2'b11
    } link_mode_e;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] blu;
        logic               vs;
        logic               hs;
        logic               de;
    } pixel_t;

    // Bits carried per lane in a mode: the frame split evenly over the lanes.
    function automatic logic [CNT_W-1:0] lane_bits(input link_mode_e m);
        case (m)
            LINK_1:  lane_bits = CNT_W'(FRAME_BITS);
            LINK_2:  lane_bits = CNT_W'(FRAME_BITS / 2);
            LINK_3:  lane_bits = CNT_W'(FRAME_BITS / 3);
            default: lane_bits = CNT_W'(FRAME_BITS);
        endcase
    endfunction

endpackage

// File: rtl/lane_shifter.sv
module lane_shifter #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    output logic [W-1:0] window
);
    // Oldest bit at window[W-1], the bit being sampled now at window[0].
    logic [W-2:0] hist_d, hist_q;

    always_comb begin
        window = {hist_q, bit_in};
        hist_d = window[W-2:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/frame_mapper.sv
module frame_mapper
    import pixdeser_pkg::*;
(
    input  link_mode_e              mode,
    input  logic [FRAME_BITS-1:0]   win0,
    input  logic [FRAME_BITS/2-1:0] win1,
    input  logic [FRAME_BITS/3-1:0] win2,
    output pixel_t                  pix,
    output logic                    cp
);
    // Window bit 0 is the last bit of the frame on that lane.
    always_comb begin
        pix = '0;
        cp  = 1'b0;
        case (mode)
            LINK_1: begin
                pix.red = win0[29:22];
                pix.grn = win0[21:14];
                pix.blu = win0[13:6];
                pix.vs  = win0[5];
                pix.hs  = win0[4];
                pix.de  = win0[3];
                cp      = win0[0];
            end
            LINK_2: begin
                pix.red = win0[14:7];
                pix.grn = {win0[6:3], win1[14:11]};
                pix.blu = win1[10:3];
                pix.vs  = win0[2];
                pix.hs  = win1[2];
                pix.de  = win1[1];
                cp      = win0[0];
            end
            LINK_3: begin
                pix.red = win0[9:2];
                pix.vs  = win0[1];
                cp      = win0[0];
                pix.grn = win1[9:2];
                pix.hs  = win1[1];
                pix.blu = win2[9:2];
                pix.de  = win2[1];
            end
            default: begin
                pix = '0;
                cp  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/parity_check.sv
module parity_check
    import pixdeser_pkg::*;
#(
    parameter bit ODD_PARITY = 1'b0
) (
    input  pixel_t pix,
    input  logic   cp,
    output logic   mismatch
);
    always_comb begin
        mismatch = (^pix) ^ cp ^ ODD_PARITY;
    end
endmodule

// File: rtl/pixdeser_top.sv
module pixdeser_top
    import pixdeser_pkg::*;
#(
    parameter bit ODD_PARITY = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           link_sel,
    input  logic                 frame_start,
    input  logic [NUM_LANES-1:0] lane_in,
    output logic [COLOR_W-1:0]   pix_red,
    output logic [COLOR_W-1:0]   pix_grn,
    output logic [COLOR_W-1:0]   pix_blu,
    output logic                 vsync,
    output logic                 hsync,
    output logic                 den,
    output logic                 pix_valid,
    output logic                 parity_error
);

    typedef struct packed {
        logic [1:0]       ls;
        logic             armed;
        logic [CNT_W-1:0] cnt;
        pixel_t           pix;
        logic             valid;
        logic             perr;
    } state_t;

    state_t st_d, st_q;

    logic [FRAME_BITS-1:0]   win0;
    logic [FRAME_BITS/2-1:0] win1;
    logic [FRAME_BITS/3-1:0] win2;

    // One shifter per lane; lane i holds FRAME_BITS/(i+1) bits.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int LW = FRAME_BITS / (i + 1);
        logic [LW-1:0] w;
        lane_shifter #(.W(LW)) u_shift (
            .clk    (clk),
            .rst_n  (rst_n),
            .bit_in (lane_in[i]),
            .window (w)
        );
        if (i == 0) begin : g_w0
            assign win0 = w;
        end else if (i == 1) begin : g_w1
            assign win1 = w;
        end else begin : g_w2
            assign win2 = w;
        end
    end

    link_mode_e mode;
    pixel_t     map_pix;
    logic       map_cp;
    logic       map_err;

    assign mode = link_mode_e'(link_sel);

    frame_mapper u_map (
        .mode (mode),
        .win0 (win0),
        .win1 (win1),
        .win2 (win2),
        .pix  (map_pix),
        .cp   (map_cp)
    );

    parity_check #(.ODD_PARITY(ODD_PARITY)) u_par (
        .pix      (map_pix),
        .cp       (map_cp),
        .mismatch (map_err)
    );

    logic [CNT_W-1:0] last_idx;
    assign last_idx = lane_bits(mode) - CNT_W'(1);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.perr  = 1'b0;
        st_d.ls    = link_sel;
        if (link_sel != st_q.ls || mode == LINK_RSVD) begin
            // Discard any partial frame and wait for realignment.
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (frame_start) begin
            st_d.armed = 1'b1;
            st_d.cnt   = CNT_W'(1);
        end else if (st_q.armed) begin
            if (st_q.cnt == last_idx) begin
                st_d.cnt   = '0;
                st_d.valid = 1'b1;
                st_d.pix   = map_pix;
                st_d.perr  = map_err;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_red      = st_q.pix.red;
    assign pix_grn      = st_q.pix.grn;
    assign pix_blu      = st_q.pix.blu;
    assign vsync        = st_q.pix.vs;
    assign hsync        = st_q.pix.hs;
    assign den          = st_q.pix.de;
    assign pix_valid    = st_q.valid;
    assign parity_error = st_q.perr;

endmodule

// File: rtl/pixdeser_checks.sv
module pixdeser_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] link_sel,
    input logic [7:0] pix_red,
    input logic [7:0] pix_grn,
    input logic [7:0] pix_blu,
    input logic       vsync,
    input logic       hsync,
    input logic       den,
    input logic       pix_valid,
    input logic       parity_error
);
    logic [26:0] word;
    assign word = {pix_red, pix_grn, pix_blu, vsync, hsync, den};

    // Cycles since the last strobe, saturating; seen marks a first strobe.
    logic [4:0] gap_q;
    logic       seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (pix_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 5'd31) begin
            gap_q <= gap_q + 5'd1;
        end
    end

    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> $stable(word));

    p_perr_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        parity_error |-> pix_valid);

    p_rsvd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_sel == 2'b11) |=> !pix_valid);

    p_switch_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_sel != $past(link_sel)) |=> !pix_valid);

    p_min_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && seen_q) |-> (gap_q >= 5'd9));

endmodule

bind pixdeser_top pixdeser_checks u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_sel     (link_sel),
    .pix_red      (pix_red),
    .pix_grn      (pix_grn),
    .pix_blu      (pix_blu),
    .vsync        (vsync),
    .hsync        (hsync),
    .den          (den),
    .pix_valid    (pix_valid),
    .parity_error (parity_error)
);

// File: tb/pixdeser_top_test.sv
module pixdeser_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] link_sel = 2'b00;
    logic       frame_start = 1'b0;
    logic [2:0] lane_in = 3'b000;
    logic [7:0] pix_red, pix_grn, pix_blu;
    logic       vsync, hsync, den, pix_valid, parity_error;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixdeser_top uut (
        .clk (clk), .rst_n (rst_n), .link_sel (link_sel),
        .frame_start (frame_start), .lane_in (lane_in),
        .pix_red (pix_red), .pix_grn (pix_grn), .pix_blu (pix_blu),
        .vsync (vsync), .hsync (hsync), .den (den),
        .pix_valid (pix_valid), .parity_error (parity_error)
    );

    int checks = 0;
    int failures = 0;
    int stab_bad = 0;
    int cyc = 0;
    int prev_vcyc = -1;
    int last_gap = 0;
    bit done = 1'b0;

    logic [27:0] exp_q[$];
    string       tag_q[$];
    logic [27:0] last_word = '0;

    function automatic logic [27:0] actual();
        return {parity_error, den, hsync, vsync, pix_blu, pix_grn, pix_red};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [27:0] act, input logic [27:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops the scoreboard on every strobe.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pix_valid) begin
                    if (prev_vcyc >= 0) last_gap = cyc - prev_vcyc;
                    prev_vcyc = cyc;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 or R10 unexpected strobe", actual(), '0);
                    end else begin
                        logic [27:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(actual() == e, t, actual(), e);
                    end
                    last_word = actual() & 28'h7FF_FFFF;
                end else if ((actual() & 28'h7FF_FFFF) != last_word
                             || parity_error) begin
                    stab_bad++;
                end
            end
        end
    end

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        link_sel = m;
        frame_start = 1'b0;
        @(negedge clk);
    endtask

    // Driver: builds the per-lane bit order from the requirements.
    task automatic send_frame(input logic [1:0] m, input logic [7:0] r,
                              input logic [7:0] g, input logic [7:0] b,
                              input logic vs, input logic hs, input logic de,
                              input bit bad, input logic rv, input bit junk,
                              input bit push, input string tag);
        logic [29:0] s0, s1, s2;
        logic        cp;
        int          n;
        cp = (^{r, g, b, vs, hs, de}) ^ bad;
        s0 = '0; s1 = '0; s2 = '0;
        case (m)
            2'b00: begin n = 30; s0 = {r, g, b, vs, hs, de, rv, rv, cp}; end
            2'b01: begin
                n = 15;
                s0 = 30'({r, g[7:4], vs, rv, cp});
                s1 = 30'({g[3:0], b, hs, de, rv});
            end
            2'b10: begin
                n = 10;
                s0 = 30'({r, vs, cp});
                s1 = 30'({g, hs, rv});
                s2 = 30'({b, de, rv});
            end
            default: begin n = 30; s0 = {r, g, b, vs, hs, de, rv, rv, cp}; end
        endcase
        if (push) begin
            exp_q.push_back({bad, de, hs, vs, b, g, r});
            tag_q.push_back(tag);
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            frame_start = (k == 0);
            lane_in[0] = s0[n-1-k];
            lane_in[1] = (m == 2'b00) ? (junk ? 1'($urandom) : 1'b0) : s1[n-1-k];
            lane_in[2] = (m != 2'b10) ? (junk ? 1'($urandom) : 1'b0) : s2[n-1-k];
        end
    endtask

    task automatic send_partial(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            frame_start = (k == 0);
            lane_in = 3'($urandom);
        end
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            frame_start = 1'b0;
            lane_in = 3'b000;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(actual() == '0 && !pix_valid, "R1 during reset", actual(), '0);
        rst_n = 1'b1;
        idle(3);
        check(actual() == '0 && !pix_valid, "R1 after reset", actual(), '0);

        // One lane, back to back.
        send_frame(2'b00, 8'hA5, 8'h3C, 8'hF0, 1, 0, 1, 0, 0, 0, 1, "R2 one-lane map");
        send_frame(2'b00, 8'h12, 8'hEF, 8'h81, 0, 1, 1, 0, 0, 1, 1, "R6 idle lanes one-lane");
        send_frame(2'b00, 8'h5A, 8'h00, 8'hFF, 1, 1, 0, 0, 1, 0, 1, "R5 filler set one-lane");
        send_frame(2'b00, 8'h77, 8'h88, 8'h99, 0, 0, 1, 1, 0, 0, 1, "R7 bad parity one-lane");
        idle(3);
        check(last_gap == 30, "R2 strobe period", 28'(last_gap), 28'd30);

        set_mode(2'b01);
        send_frame(2'b01, 8'hC3, 8'h96, 8'h4B, 1, 0, 0, 0, 0, 1, 1, "R3 two-lane map, R6 lane 2");
        send_frame(2'b01, 8'h0F, 8'hF1, 8'h2D, 0, 1, 1, 0, 1, 0, 1, "R5 filler set two-lane");
        idle(3);
        check(last_gap == 15, "R3 strobe period", 28'(last_gap), 28'd15);

        set_mode(2'b10);
        send_frame(2'b10, 8'h81, 8'h42, 8'h24, 1, 1, 1, 0, 0, 0, 1, "R4 three-lane map");
        send_frame(2'b10, 8'hFE, 8'h7F, 8'hB6, 0, 0, 1, 0, 1, 0, 1, "R4 R5 three-lane filler");
        send_frame(2'b10, 8'h13, 8'h57, 8'h9B, 1, 0, 1, 1, 0, 0, 1, "R7 bad parity three-lane");
        idle(3);
        check(last_gap == 10, "R4 strobe period", 28'(last_gap), 28'd10);

        // Realignment by a mid-frame pulse.
        send_partial(4);
        send_frame(2'b10, 8'h6C, 8'hD2, 8'h1E, 0, 1, 0, 0, 0, 0, 1, "R11 realign");
        idle(5);

        // Select change discards a partial frame.
        set_mode(2'b01);
        send_partial(7);
        set_mode(2'b00);
        idle(40);
        check(exp_q.size() == 0, "R9 no pending strobe", 28'(exp_q.size()), 28'd0);
        send_frame(2'b00, 8'h39, 8'hC6, 8'h5D, 1, 1, 1, 0, 0, 0, 1, "R9 frame after switch");
        idle(5);

        // Reserved code: no strobe, outputs held.
        set_mode(2'b11);
        send_frame(2'b11, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1, 0, 1, 1, 0, "R10");
        idle(40);
        check((actual() & 28'h7FF_FFFF) == {1'b0, 1'b1, 1'b1, 1'b1, 8'h5D, 8'hC6, 8'h39},
              "R10 outputs held", actual(), {1'b0, 1'b1, 1'b1, 1'b1, 8'h5D, 8'hC6, 8'h39});
        set_mode(2'b00);
        send_frame(2'b00, 8'h01, 8'h80, 8'h44, 0, 0, 0, 0, 0, 0, 1, "R2 after reserved");
        idle(5);

        check(exp_q.size() == 0, "R8 all frames strobed", 28'(exp_q.size()), 28'd0);
        check(stab_bad == 0, "R8 output stable between strobes", 28'(stab_bad), 28'd0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end
endmodule